// File: doc/BRIEF.md
# Host Bridge Interrupt Router

This block sits in a host bridge between 48 level-sensitive interrupt sources and 48 interrupt vector outputs. Sources 0 to 31 are PCI slot lines. Sources 32 to 47 are on-board I/O lines. Each output follows its source only while the governing mapping register has its enable bit set. A small register bus with 16-bit byte offsets and 32-bit data reaches the mapping registers and a set of clear registers. Software uses the clear registers to drop a vector until its source moves again.

Each 8-byte slot holds one 32-bit register in its upper word (offset bit 2 set). The lower word is inert. Four PCI lines share each PCI mapping register, so there are 8 of them. Each on-board line has a mapping register of its own. A mapping register reads back the enable in bit 31 above a fixed read-only field. A synchronous reset clears every enable and every pending clear, and leaves the fixed fields as they are.

Top module: `irq_router`

## Requirements
- R1: While and after reset, every vector output is low and the read data is zero.
- R2: A read of the PCI mapping register at offset 0x0C04+8*i (i 0..7) returns bit 31 = enable and bits 30:0 = 0x7C0 OR (i shifted left by 2). A read of the on-board mapping register at 0x1004+8*j (j 0..15) returns bit 31 = enable and bits 30:0 = 0x7E0 + j.
- R3: A write to a mapping register copies write-data bit 31 into the enable bit. Bits 30:0 never change.
- R4: For every mapping slot and every clear slot, the lower word (offset bit 2 clear) reads as zero and ignores writes.
- R5: PCI source n is gated by PCI mapping register n/4. Source 32+j is gated by on-board mapping register j.
- R6: While the enable is set and no clear is pending, a vector equals its source as it was two clock edges earlier. With the enable clear, the vector is low. A new enable value shows on the vector at the second edge after the write is sampled.
- R7: A write to the PCI clear register at 0x1404+8*k (k 0..7) drives vector k low from the second edge after the write. The vector stays low until that source changes level, and then follows the source again.
- R8: A write to the on-board clear register at 0x1804+8*k (k 0..11) acts on vector 32+k in the same way as R7.
- R9: Clear registers and unmapped offsets read as zero. Writes to unmapped offsets change nothing. This includes the on-board clear slots with index 12 and above, and the offset 0x1084.
- R10: A reset during operation clears every enable and every pending clear. The fixed fields read back unchanged afterwards.
- R11: Read data appears at the edge after the read is sampled. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte offset |
| bus_wdata_i | input | 32 | Write data (only bit 31 is used) |
| bus_rdata_o | output | 32 | Registered read data |
| src_lvl_i | input | 48 | Source levels: 0..31 PCI, 32..47 on-board |
| vec_o | output | 48 | Gated interrupt vector outputs |

## Verification
Read data is due at the first edge after the read is sampled. Every vector effect is due at the second edge after its cause is sampled: a source change, an enable write or a clear write. The bench tracks a cycle number. Each expected item it queues carries the cycle in which it falls due. The monitor compares items only in that cycle, at the falling edge. An item still queued after its cycle counts as a failure.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Byte distance between register slots, and the offset of the live word.
  localparam int unsigned SLOT_STRIDE = 8;
  localparam int unsigned LIVE_WORD   = 4;

  // Read-only fields held below the enable bit.
  localparam logic [30:0] FIXED_BASE = 31'h7C0;
  localparam logic [30:0] OBD_BIAS   = 31'h20;

  typedef enum logic [1:0] {
    RDK_ZERO = 2'd0,
    RDK_PCI  = 2'd1,
    RDK_OBD  = 2'd2
  } rd_kind_e;

  function automatic logic [30:0] pci_fixed(input int unsigned idx);
    return FIXED_BASE | 31'(idx << 2);
  endfunction

  function automatic logic [30:0] obd_fixed(input int unsigned idx);
    return (FIXED_BASE | OBD_BIAS) + 31'(idx);
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned PCI_MAPS     = 8,
  parameter int unsigned OBD_MAPS     = 16,
  parameter int unsigned PCI_CLRS     = 8,
  parameter int unsigned OBD_CLRS     = 12,
  parameter int unsigned PCI_SRCS     = 32,
  parameter int unsigned NVEC         = 48,
  parameter int unsigned IDX_W        = 4,
  parameter int unsigned PCI_MAP_BASE = 'h0C00,
  parameter int unsigned OBD_MAP_BASE = 'h1000,
  parameter int unsigned PCI_CLR_BASE = 'h1400,
  parameter int unsigned OBD_CLR_BASE = 'h1800
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PCI_MAPS-1:0] pci_we_o,
  output logic [OBD_MAPS-1:0] obd_we_o,
  output logic [NVEC-1:0]   clr_o,
  output logic              rd_o,
  output rd_kind_e          rd_kind_o,
  output logic [IDX_W-1:0]  rd_idx_o
);

  localparam int unsigned WA = ADDR_W - 2;

  logic [WA-1:0] word;
  logic          wr_req;
  logic          unused_lanes;

  assign word         = addr_i[ADDR_W-1:2];
  assign unused_lanes = ^addr_i[1:0];
  assign wr_req       = sel_i & wr_i;
  assign rd_o         = sel_i & ~wr_i;

  function automatic logic [WA-1:0] live_word(input int unsigned base, input int unsigned i);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(base + SLOT_STRIDE * i + LIVE_WORD);
    return a[ADDR_W-1:2];
  endfunction

  logic [PCI_MAPS-1:0] pci_map_hit;
  logic [OBD_MAPS-1:0] obd_map_hit;
  logic [PCI_CLRS-1:0] pci_clr_hit;
  logic [OBD_CLRS-1:0] obd_clr_hit;

  for (genvar i = 0; i < PCI_MAPS; i++) begin : g_pci_map
    assign pci_map_hit[i] = (word == live_word(PCI_MAP_BASE, i));
  end
  for (genvar j = 0; j < OBD_MAPS; j++) begin : g_obd_map
    assign obd_map_hit[j] = (word == live_word(OBD_MAP_BASE, j));
  end
  for (genvar k = 0; k < PCI_CLRS; k++) begin : g_pci_clr
    assign pci_clr_hit[k] = (word == live_word(PCI_CLR_BASE, k));
  end
  for (genvar k = 0; k < OBD_CLRS; k++) begin : g_obd_clr
    assign obd_clr_hit[k] = (word == live_word(OBD_CLR_BASE, k));
  end

  assign pci_we_o = pci_map_hit & {PCI_MAPS{wr_req}};
  assign obd_we_o = obd_map_hit & {OBD_MAPS{wr_req}};

  // Clear strobes: PCI clear k drives vector k, on-board clear k drives vector PCI_SRCS+k.
  for (genvar n = 0; n < NVEC; n++) begin : g_clr
    if (n < PCI_CLRS) begin : g_pci
      assign clr_o[n] = wr_req & pci_clr_hit[n];
    end else if ((n >= PCI_SRCS) && (n < PCI_SRCS + OBD_CLRS)) begin : g_obd
      assign clr_o[n] = wr_req & obd_clr_hit[n-PCI_SRCS];
    end else begin : g_none
      assign clr_o[n] = 1'b0;
    end
  end

  always_comb begin
    rd_kind_o = RDK_ZERO;
    rd_idx_o  = '0;
    for (int unsigned i = 0; i < PCI_MAPS; i++) begin
      if (pci_map_hit[i]) begin
        rd_kind_o = RDK_PCI;
        rd_idx_o  = IDX_W'(i);
      end
    end
    for (int unsigned j = 0; j < OBD_MAPS; j++) begin
      if (obd_map_hit[j]) begin
        rd_kind_o = RDK_OBD;
        rd_idx_o  = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PCI_MAPS     = 8,
  parameter int unsigned OBD_MAPS     = 16,
  parameter int unsigned PCI_SRCS     = 32,
  parameter int unsigned SRCS_PER_MAP = 4,
  parameter int unsigned NVEC         = 48,
  parameter int unsigned IDX_W        = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PCI_MAPS-1:0] pci_we_i,
  input  logic [OBD_MAPS-1:0] obd_we_i,
  input  logic                wbit_i,
  input  logic                rd_i,
  input  rd_kind_e            rd_kind_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NVEC-1:0]     en_vec_o
);

  logic [PCI_MAPS-1:0] pci_en_q;
  logic [OBD_MAPS-1:0] obd_en_q;
  logic [DATA_W-1:0]   rd_next;
  logic [DATA_W-1:0]   rdata_q;

  // Only the enable bits are stored; the fields below them are constants.
  always_ff @(posedge clk) begin
    if (rst) begin
      pci_en_q <= '0;
      obd_en_q <= '0;
    end else begin
      for (int unsigned i = 0; i < PCI_MAPS; i++) begin
        if (pci_we_i[i]) pci_en_q[i] <= wbit_i;
      end
      for (int unsigned j = 0; j < OBD_MAPS; j++) begin
        if (obd_we_i[j]) obd_en_q[j] <= wbit_i;
      end
    end
  end

  // Fan each enable out to the sources it governs.
  for (genvar n = 0; n < NVEC; n++) begin : g_fan
    if (n < PCI_SRCS) begin : g_pci
      assign en_vec_o[n] = pci_en_q[n / SRCS_PER_MAP];
    end else begin : g_obd
      assign en_vec_o[n] = obd_en_q[n - PCI_SRCS];
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_kind_i)
      RDK_PCI: begin
        if (int'(rd_idx_i) < int'(PCI_MAPS)) begin
          rd_next[DATA_W-2:0] = (DATA_W-1)'(pci_fixed(int'(rd_idx_i)));
          rd_next[DATA_W-1]   = pci_en_q[rd_idx_i];
        end
      end
      RDK_OBD: begin
        if (int'(rd_idx_i) < int'(OBD_MAPS)) begin
          rd_next[DATA_W-2:0] = (DATA_W-1)'(obd_fixed(int'(rd_idx_i)));
          rd_next[DATA_W-1]   = obd_en_q[rd_idx_i];
        end
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  for (genvar i = 0; i < PCI_MAPS; i++) begin : g_pci_chk
    assert_enable_write_pci_R3: assert property (@(posedge clk) disable iff (rst)
      pci_we_i[i] |=> (pci_en_q[i] == $past(wbit_i)));
  end
  for (genvar j = 0; j < OBD_MAPS; j++) begin : g_obd_chk
    assert_enable_write_obd_R3: assert property (@(posedge clk) disable iff (rst)
      obd_we_i[j] |=> (obd_en_q[j] == $past(wbit_i)));
  end

  assert_reset_drops_enables_R10: assert property (@(posedge clk)
    rst |=> ((pci_en_q == '0) && (obd_en_q == '0)));

  assert_zero_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (rd_kind_i == RDK_ZERO)) |=> (rdata_o == '0));

endmodule

// File: rtl/irq_vec_gate.sv
module irq_vec_gate #(
  parameter int unsigned NVEC = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NVEC-1:0] src_i,
  input  logic [NVEC-1:0] en_i,
  input  logic [NVEC-1:0] clr_i,
  output logic [NVEC-1:0] vec_o
);

  logic [NVEC-1:0] src_q;
  logic [NVEC-1:0] clr_q;
  logic [NVEC-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      clr_q <= '0;
      vec_q <= '0;
    end else begin
      src_q <= src_i;
      // A pending clear ends when the incoming level differs from the held one.
      clr_q <= clr_i | (clr_q & ~(src_i ^ src_q));
      vec_q <= src_q & en_i & ~clr_q;
    end
  end

  assign vec_o = vec_q;

  for (genvar n = 0; n < NVEC; n++) begin : g_chk
    // Covers the PCI clears and the on-board clears (R7_R8).
    assert_clear_forces_low_R7: assert property (@(posedge clk) disable iff (rst)
      clr_q[n] |=> !vec_o[n]);
    assert_disabled_is_low_R6: assert property (@(posedge clk) disable iff (rst)
      !en_i[n] |=> !vec_o[n]);
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PCI_SRCS     = 32,
  parameter int unsigned SRCS_PER_MAP = 4,
  parameter int unsigned OBD_SRCS     = 16,
  parameter int unsigned PCI_CLRS     = 8,
  parameter int unsigned OBD_CLRS     = 12,
  parameter int unsigned PCI_MAP_BASE = 'h0C00,
  parameter int unsigned OBD_MAP_BASE = 'h1000,
  parameter int unsigned PCI_CLR_BASE = 'h1400,
  parameter int unsigned OBD_CLR_BASE = 'h1800
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_sel_i,
  input  logic                         bus_wr_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [DATA_W-1:0]            bus_wdata_i,
  output logic [DATA_W-1:0]            bus_rdata_o,
  input  logic [PCI_SRCS+OBD_SRCS-1:0] src_lvl_i,
  output logic [PCI_SRCS+OBD_SRCS-1:0] vec_o
);

  localparam int unsigned PCI_MAPS = PCI_SRCS / SRCS_PER_MAP;
  localparam int unsigned OBD_MAPS = OBD_SRCS;
  localparam int unsigned NVEC     = PCI_SRCS + OBD_SRCS;
  localparam int unsigned MAX_MAPS = (OBD_MAPS > PCI_MAPS) ? OBD_MAPS : PCI_MAPS;
  localparam int unsigned IDX_W    = (MAX_MAPS > 1) ? $clog2(MAX_MAPS) : 1;

  logic [PCI_MAPS-1:0] pci_we;
  logic [OBD_MAPS-1:0] obd_we;
  logic [NVEC-1:0]     clr_stb;
  logic [NVEC-1:0]     en_vec;
  logic                rd_req;
  rd_kind_e            rd_kind;
  logic [IDX_W-1:0]    rd_idx;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-2:0];

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .PCI_MAPS(PCI_MAPS), .OBD_MAPS(OBD_MAPS),
    .PCI_CLRS(PCI_CLRS), .OBD_CLRS(OBD_CLRS), .PCI_SRCS(PCI_SRCS),
    .NVEC(NVEC), .IDX_W(IDX_W),
    .PCI_MAP_BASE(PCI_MAP_BASE), .OBD_MAP_BASE(OBD_MAP_BASE),
    .PCI_CLR_BASE(PCI_CLR_BASE), .OBD_CLR_BASE(OBD_CLR_BASE)
  ) u_decode (
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .pci_we_o(pci_we), .obd_we_o(obd_we), .clr_o(clr_stb),
    .rd_o(rd_req), .rd_kind_o(rd_kind), .rd_idx_o(rd_idx)
  );

  irq_map_regs #(
    .DATA_W(DATA_W), .PCI_MAPS(PCI_MAPS), .OBD_MAPS(OBD_MAPS),
    .PCI_SRCS(PCI_SRCS), .SRCS_PER_MAP(SRCS_PER_MAP), .NVEC(NVEC), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .pci_we_i(pci_we), .obd_we_i(obd_we),
    .wbit_i(bus_wdata_i[DATA_W-1]), .rd_i(rd_req), .rd_kind_i(rd_kind),
    .rd_idx_i(rd_idx), .rdata_o(bus_rdata_o), .en_vec_o(en_vec)
  );

  irq_vec_gate #(
    .NVEC(NVEC)
  ) u_gate (
    .clk(clk), .rst(rst), .src_i(src_lvl_i), .en_i(en_vec),
    .clr_i(clr_stb), .vec_o(vec_o)
  );

  assert_reset_outputs_low_R1: assert property (@(posedge clk)
    rst |=> ((vec_o == '0) && (bus_rdata_o == '0)));

endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [47:0] src = '0;
  logic [31:0] rdata;
  logic [47:0] vec;

  always #4 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst(rst), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_lvl_i(src), .vec_o(vec)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  // Scoreboard queues: due cycle, read-or-vector, expected value, tag.
  int          q_due[$];
  bit          q_rd[$];
  logic [47:0] q_val[$];
  string       q_tag[$];

  // Requirement model.
  bit          m_pen[8];
  bit          m_oen[16];
  logic [47:0] m_src = '0;
  logic [47:0] m_clr = '0;

  function automatic logic [47:0] model_vec();
    logic [47:0] v;
    for (int n = 0; n < 48; n++) begin
      bit en;
      en = (n < 32) ? m_pen[n/4] : m_oen[n-32];
      v[n] = m_src[n] & en & ~m_clr[n];
    end
    return v;
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int d, bit is_rd, logic [47:0] v, string tag);
    q_due.push_back(cyc + d);
    q_rd.push_back(is_rd);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare items exactly in their due cycle.
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      int          d;
      bit          r;
      logic [47:0] v;
      string       t;
      d = q_due.pop_front();
      r = q_rd.pop_front();
      v = q_val.pop_front();
      t = q_tag.pop_front();
      if (d < cyc) check({t, " (stale)"}, 48'hDEAD, v);
      else if (r)  check(t, {16'h0, rdata}, v);
      else         check(t, vec, v);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_write(logic [15:0] a, logic [31:0] d);
    for (int i = 0; i < 8; i++)  if (a == 16'(32'h0C04 + 8*i)) m_pen[i] = d[31];
    for (int j = 0; j < 16; j++) if (a == 16'(32'h1004 + 8*j)) m_oen[j] = d[31];
    for (int k = 0; k < 8; k++)  if (a == 16'(32'h1404 + 8*k)) m_clr[k] = 1'b1;
    for (int k = 0; k < 12; k++) if (a == 16'(32'h1804 + 8*k)) m_clr[32+k] = 1'b1;
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    model_write(a, d);
    push(2, 1'b0, model_vec(), tag);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    idle(2);
  endtask

  task automatic bus_read(logic [15:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    push(1, 1'b1, {16'h0, exp}, tag);
    @(negedge clk);
    sel = 1'b0;
    idle(2);
  endtask

  task automatic set_src(logic [47:0] v, string tag);
    @(negedge clk);
    m_clr = m_clr & ~(v ^ m_src);
    m_src = v;
    src = v;
    push(2, 1'b0, model_vec(), tag);
    idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 8; i++)  m_pen[i] = 1'b0;
    for (int j = 0; j < 16; j++) m_oen[j] = 1'b0;
    m_clr = '0;
    idle(2);
    check("R1 vec in reset", vec, '0);
    check("R1 rdata in reset", {16'h0, rdata}, '0);
    rst = 1'b0;
    push(2, 1'b0, model_vec(), "R10 vec after reset");
    idle(3);
  endtask

  localparam logic [47:0] ONES = {48{1'b1}};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 8; i++)  m_pen[i] = 1'b0;
    for (int j = 0; j < 16; j++) m_oen[j] = 1'b0;
    idle(3);
    check("R1 vec in reset", vec, '0);
    check("R1 rdata in reset", {16'h0, rdata}, '0);
    rst = 1'b0;
    idle(2);

    // R2 fixed fields after reset
    bus_read(16'h0C0C, 32'h0000_07C4, "R2 pci map 1");
    bus_read(16'h0C1C, 32'h0000_07CC, "R2 pci map 3");
    bus_read(16'h1014, 32'h0000_07E2, "R2 obd map 2");
    bus_read(16'h103C, 32'h0000_07E7, "R2 obd map 7");
    bus_read(16'h107C, 32'h0000_07EF, "R2 obd map 15");

    // R6 disabled gating
    set_src(ONES, "R6 all disabled stays low");

    // R3 only bit 31 written
    bus_write(16'h0C0C, 32'hFFFF_FFFF, "R5 group 1 drives vectors 4..7");
    bus_read(16'h0C0C, 32'h8000_07C4, "R3 enable set, field intact");
    bus_write(16'h0C1C, 32'h7FFF_FFFF, "R3 write with bit31 clear");
    bus_read(16'h0C1C, 32'h0000_07CC, "R3 bits 30:0 read-only");

    // R4 lower words
    bus_write(16'h0C18, 32'h8000_0000, "R4 lower word write ignored");
    bus_read(16'h0C1C, 32'h0000_07CC, "R4 enable untouched");
    bus_read(16'h0C18, 32'h0000_0000, "R4 lower word reads zero");

    // R5 grouping
    bus_write(16'h1014, 32'h8000_0000, "R5 obd map 2 drives vector 34");
    bus_write(16'h0C1C, 32'h8000_0000, "R5 group 3 drives vectors 12..15");

    // R6 following the source
    set_src(48'hA5A5_1234_5678, "R6 follows pattern A");
    set_src(48'h5A5A_EDCB_A987, "R6 follows pattern B");
    set_src(ONES, "R6 follows all ones");

    // R7 PCI clear of vector 5
    bus_write(16'h142C, 32'h0000_0000, "R7 clear forces vector 5 low");
    set_src(ONES & ~48'h10, "R7 held low while other lines move");
    set_src(ONES & ~48'h30, "R7 source change releases");
    set_src(ONES, "R7 follows source again");

    // R8 on-board clear of vector 34
    bus_write(16'h1814, 32'h0000_0000, "R8 clear forces vector 34 low");
    set_src(ONES & ~(48'h1 << 34), "R8 release on fall");
    set_src(ONES, "R8 follows source again");

    // R9 out-of-range and unmapped offsets
    bus_write(16'h1064, 32'h8000_0000, "R5 obd map 12 drives vector 44");
    bus_write(16'h1864, 32'h0000_0000, "R9 obd clear index 12 no effect");
    bus_write(16'h1428, 32'h0000_0000, "R4 clear lower word no effect");
    bus_write(16'h2004, 32'hFFFF_FFFF, "R9 unmapped write no effect");
    bus_read(16'h142C, 32'h0000_0000, "R9 clear register reads zero");
    bus_read(16'h2004, 32'h0000_0000, "R9 unmapped read zero");
    bus_read(16'h1084, 32'h0000_0000, "R9 obd slot 16 reads zero");

    // R11 read data holds
    bus_read(16'h1064, 32'h8000_07EC, "R11 obd map 12 read");
    push(1, 1'b1, {16'h0, 32'h8000_07EC}, "R11 read data held");
    idle(3);

    // R6 disabling
    bus_write(16'h1014, 32'h0000_0000, "R6 disable drops vector 34");

    // R10 reset mid-run with a pending clear
    bus_write(16'h0C04, 32'h8000_0000, "R6 enable vectors 0..3");
    bus_write(16'h1404, 32'h0000_0000, "R7 clear vector 0");
    do_reset();
    bus_read(16'h0C0C, 32'h0000_07C4, "R10 pci field kept, enable cleared");
    bus_read(16'h1064, 32'h0000_07EC, "R10 obd field kept, enable cleared");
    bus_write(16'h0C04, 32'h8000_0000, "R10 no pending clear after reset");

    idle(4);
    if (q_due.size() != 0) check("R11 scoreboard drained", 48'(q_due.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule